// File: doc/BRIEF.md
# Two-Byte Conversion Result Readout

This block sits between a 10-bit conversion sequencer and an 8-bit microprocessor data bus. When the sequencer signals that a conversion has finished, the block captures the result into an output latch. It then presents the result as two bytes, read one after the other. The first byte holds the upper eight result bits. The second byte holds the two lowest result bits in its top positions, with its lower six positions forced to zero. This gives a left-justified 16-bit word read high byte first.

The block also drives an active-low interrupt line. The end of a transfer fires a one-shot that sets the interrupt flag for a fixed number of system clocks. A read with chip select and read strobe both low clears the flag. While the one-shot is running, the set wins over the clear. A host that keeps its read strobe asserted all the time therefore still sees the interrupt line go low once per conversion.

All inputs are synchronous to `clk`. The data bus is given as a data vector plus an output enable. A pad ring turns these into a tri-state bus: the bus floats whenever the enable is low.

Top module: `dual_byte_readout`

## Requirements
- R1: After reset, `irq_n` is high, `dbus_oe` is low, `dbus` is all zero, and the byte pointer selects the high byte.
- R2: `dbus_oe` is high exactly when `cs_n` and `rd_n` are both low. If either one is high, it is low.
- R3: Whenever `dbus_oe` is low, `dbus` is driven to all zero, standing for high impedance.
- R4: The first read after a transfer puts result bits 9..2 on `dbus` bits 7..0.
- R5: The second read puts result bits 1..0 on `dbus` bits 7..6 and zero on `dbus` bits 5..0.
- R6: A completed read advances the byte pointer when read ends, that is when `cs_n` or `rd_n` returns high. After the second read, the pointer wraps back to the high byte.
- R7: If `xfer` is sampled high at one clock edge and low at the next, `irq_n` is low after that second edge.
- R8: Once the set pulse has ended, a clock edge that samples `cs_n` and `rd_n` both low clears the flag, so `irq_n` is high after that edge.
- R9: The set pulse holds the flag for `PULSE_CYC` edges, counted from the edge that detects the falling `xfer`, and it overrides any read. If the read is held active for the whole time, `irq_n` is low for exactly `PULSE_CYC` cycles and then returns high.
- R10: The result is latched at the edge that detects the falling `xfer`. Later changes on `result` do not reach `dbus` until the next transfer.
- R11: A transfer returns the byte pointer to the high byte, even if only one byte of the previous result was read.
- R12: If only one of `cs_n` or `rd_n` goes low, nothing happens: the pointer does not advance and the flag is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| xfer | input | 1 | Transfer pulse from the sequencer; its falling edge marks a new result |
| result | input | RES_W | Finished conversion result |
| dbus | output | BUS_W | Byte presented to the data bus |
| dbus_oe | output | 1 | Output enable for the tri-state data pads |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check these rules on every cycle:
- the bus enable follows the read condition, and the bus is zero while the enable is low;
- the interrupt drops on every falling transfer and stays low while the set pulse runs;
- a read clears the flag once the pulse has ended;
- the bus holds steady during a read that overlaps no transfer;
- each transfer returns the pointer to the high byte.

Only the bench scenarios can show the rest:
- the byte contents and field positions;
- the wrap-around after two reads;
- the exact length of the low interrupt under a read that never ends;
- that single-strobe glitches leave the pointer and flag alone.

// File: rtl/dual_byte_readout.sv
module dual_byte_readout #(
  parameter int RES_W     = 10,
  parameter int BUS_W     = 8,
  parameter int PULSE_CYC = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             xfer,
  input  logic [RES_W-1:0] result,
  output logic [BUS_W-1:0] dbus,
  output logic             dbus_oe,
  output logic             irq_n
);
  localparam int LO_W  = RES_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic             xfer_q, rd_q, byte_sel, irq_flag;
  logic [RES_W-1:0] held;
  logic [CNT_W-1:0] pulse_cnt;

  wire rd_act    = !cs_n && !rd_n;
  wire xfer_fall = xfer_q && !xfer;
  wire set_now   = xfer_fall || (pulse_cnt != '0);
  wire rd_done   = rd_q && !rd_act;

  wire [BUS_W-1:0] hi_byte = held[RES_W-1 -: BUS_W];
  wire [BUS_W-1:0] lo_byte = {held[LO_W-1:0], {PAD_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q    <= 1'b0;
      rd_q      <= 1'b0;
      byte_sel  <= 1'b0;
      irq_flag  <= 1'b0;
      held      <= '0;
      pulse_cnt <= '0;
    end else begin
      xfer_q   <= xfer;
      rd_q     <= rd_act;
      irq_flag <= set_now || (irq_flag && !rd_act);
      if (xfer_fall) begin
        held      <= result;
        pulse_cnt <= CNT_W'(PULSE_CYC - 1);
        byte_sel  <= 1'b0;
      end else begin
        if (pulse_cnt != '0) pulse_cnt <= pulse_cnt - 1'b1;
        if (rd_done) byte_sel <= !byte_sel;
      end
    end
  end

  assign dbus_oe = rd_act;
  assign dbus    = rd_act ? (byte_sel ? lo_byte : hi_byte) : '0;
  assign irq_n   = !irq_flag;
endmodule

module readout_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_n,
  input logic             xfer,
  input logic [BUS_W-1:0] dbus,
  input logic             dbus_oe,
  input logic             irq_n,
  input logic             set_now,
  input logic             byte_sel
);
  logic xq, fall_q, rd_prev;
  wire rd_on = !cs_n && !rd_n;
  wire fall  = xq && !xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xq <= 1'b0; fall_q <= 1'b0; rd_prev <= 1'b0;
    end else begin
      xq <= xfer; fall_q <= fall; rd_prev <= rd_on;
    end
  end

  // R2
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !dbus_oe);
  // R3
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbus_oe |-> dbus == '0);
  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !irq_n);
  // R9
  set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> !irq_n);
  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && !set_now) |=> irq_n);
  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && rd_prev && !fall_q) |-> $stable(dbus));
  // R11
  ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !byte_sel);
endmodule

bind dual_byte_readout readout_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .xfer(xfer),
  .dbus(dbus), .dbus_oe(dbus_oe), .irq_n(irq_n),
  .set_now(set_now), .byte_sel(byte_sel)
);

// File: tb/sim_dual_byte_readout.sv
module sim_dual_byte_readout;
  localparam int P = 50;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_n = 1'b1, xfer = 1'b0;
  logic [9:0] result = '0;
  logic [7:0] dbus;
  logic dbus_oe, irq_n;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dual_byte_readout u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .xfer(xfer), .result(result), .dbus(dbus), .dbus_oe(dbus_oe), .irq_n(irq_n));

  function automatic logic [7:0] hi_of(input logic [9:0] r);
    return r[9:2];
  endfunction
  function automatic logic [7:0] lo_of(input logic [9:0] r);
    return {r[1:0], 6'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_xfer(input logic [9:0] r);
    result = r; xfer = 1'b1; step();
    xfer = 1'b0; step();
    result = 10'($urandom);
  endtask

  task automatic read_byte(output logic [7:0] b);
    cs_n = 1'b0; rd_n = 1'b0; #1;
    chk("R2 oe during read", 32'(dbus_oe), 1);
    b = dbus;
    step();
    cs_n = 1'b1; rd_n = 1'b1; step();
  endtask

  task automatic fake_strobe(input bit which);
    if (which) cs_n = 1'b0; else rd_n = 1'b0;
    #1;
    chk("R2 single strobe oe", 32'(dbus_oe), 0);
    chk("R3 idle bus", 32'(dbus), 0);
    step();
    cs_n = 1'b1; rd_n = 1'b1; step();
  endtask

  initial begin
    #1600000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [9:0] r;
    int low_cnt;
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_n = 1'b1; step();
    // R1
    chk("R1 irq_n", 32'(irq_n), 1);
    chk("R1 oe", 32'(dbus_oe), 0);
    chk("R1 bus", 32'(dbus), 0);
    read_byte(b);
    chk("R1 pointer at high byte", 32'(b), 0);

    do_xfer(10'h2B5);
    chk("R7 irq low after fall", 32'(irq_n), 0);
    repeat (P) step();
    chk("R7 flag held without read", 32'(irq_n), 0);
    // R12
    fake_strobe(1'b1);
    fake_strobe(1'b0);
    chk("R12 flag kept", 32'(irq_n), 0);
    read_byte(b);
    chk("R4 high byte", 32'(b), 32'(hi_of(10'h2B5)));
    chk("R8 irq cleared by read", 32'(irq_n), 1);
    read_byte(b);
    chk("R5 low byte", 32'(b), 32'(lo_of(10'h2B5)));
    read_byte(b);
    chk("R6 wrap to high", 32'(b), 32'(hi_of(10'h2B5)));

    // R10
    do_xfer(10'h3C3);
    result = 10'h01C;
    repeat (P) step();
    read_byte(b);
    chk("R10 latched high", 32'(b), 32'(hi_of(10'h3C3)));
    // R11
    do_xfer(10'h155);
    repeat (P) step();
    read_byte(b);
    chk("R11 pointer reset", 32'(b), 32'(hi_of(10'h155)));
    read_byte(b);
    chk("R5 low byte 2", 32'(b), 32'(lo_of(10'h155)));

    // R9: read held throughout the transfer
    cs_n = 1'b0; rd_n = 1'b0; step();
    chk("R8 held read clears", 32'(irq_n), 1);
    result = 10'h2E7; xfer = 1'b1; step();
    xfer = 1'b0; step();
    low_cnt = 0;
    for (int i = 0; i < P + 5; i++) begin
      if (!irq_n) low_cnt++;
      step();
    end
    chk("R9 low width under held read", 32'(low_cnt), P);
    chk("R9 bus shows new high", 32'(dbus), 32'(hi_of(10'h2E7)));
    cs_n = 1'b1; rd_n = 1'b1; step();
    read_byte(b);
    chk("R6 low after held read", 32'(b), 32'(lo_of(10'h2E7)));

    for (int it = 0; it < 40; it++) begin
      int nrd;
      bit ptr;
      r = 10'($urandom);
      do_xfer(r);
      chk("R7 random irq", 32'(irq_n), 0);
      repeat (P) step();
      nrd = 1 + int'($urandom % 3);
      ptr = 1'b0;
      for (int k = 0; k < nrd; k++) begin
        if ($urandom % 2 == 1) fake_strobe(1'($urandom));
        read_byte(b);
        chk(ptr ? "R5 random low" : "R4 random high", 32'(b),
            ptr ? 32'(lo_of(r)) : 32'(hi_of(r)));
        ptr = !ptr;
      end
      chk("R8 random clear", 32'(irq_n), 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule